// File: doc/BRIEF.md
# Shared Soft-Repair Fuse Clock Controller

Several embedded memories share one repair analyser. After the self-test engine finishes with a memory group, this controller moves that memory's repair code from the analyser into the memory's serial fuse register. It does this with a burst of gated fuse-clock pulses. A memory ID picks the target memory. A per-ID length table, fixed at elaboration, sets how many pulses that memory's fuse chain needs. The fuse clock of every other memory stays gated off.

The analyser's shift clock is enabled in exactly the same cycles as the selected fuse clock, so the two chains move in lockstep: the analyser's serial output feeds the memory's serial input. In incremental mode the burst has three phases. First, the old code is shifted out of the memory and into the analyser. Next comes one merge cycle, where the analyser combines the old code with the new failures. Last, the merged code is shifted back in. This gives twice the fuse length plus one pulses.

Clock gating is modelled as a registered enable per memory. Each cycle with an enable high stands for one gated pulse. The enable never changes while a burst runs.

Top module: `sr_fuse_clk_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low: `fuse_en_o`, `ana_en_o`, `merge_o`, `busy_o`, `done_o` and `err_o`.
- R2: A trigger sampled while idle, with a valid ID and a nonzero length, raises `busy_o` in the next cycle. In that cycle only bit ID of `fuse_en_o` is high. Every other bit stays low for the whole burst.
- R3: In normal mode (`incr_i`=0), the selected enable stays high for exactly L consecutive cycles, where L is the table length for the ID. The default table gives ID0=6, ID1=3, ID2=0, ID3=11 and ID4=1. The fuse register therefore receives the first L bits the analyser shifts out.
- R4: `ana_en_o` is high in exactly the cycles in which some bit of `fuse_en_o` is high.
- R5: In incremental mode (`incr_i`=1) with L>0, the selected enable stays high for exactly 2L+1 consecutive cycles.
- R6: In incremental mode, `merge_o` is high for exactly one cycle: the (L+1)-th enabled cycle of the burst. It is never high in normal mode.
- R7: `done_o` is high for exactly one cycle after the last enabled cycle, and `busy_o` is low in that cycle.
- R8: When L is 0, or the ID is 5 or more, no enable rises and `busy_o` stays low. This holds in either mode. `done_o` is high in the cycle after the trigger.
- R9: A trigger sampled while `busy_o` is high is ignored: the running burst and its ID are unchanged. It also sets `err_o`, which stays high until reset.
- R10: `fuse_en_o` holds its value in every cycle in which `busy_o` is high in that cycle and in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Group-test-finished trigger from the self-test engine |
| incr_i | input | 1 | Incremental (merge) mode, sampled with the trigger |
| mem_id_i | input | ID_W (3) | Target memory ID, sampled with the trigger |
| fuse_en_o | output | N_MEM (5) | One-hot fuse-clock enables, one bit per memory |
| ana_en_o | output | 1 | Shift-clock enable for the shared analyser |
| merge_o | output | 1 | One-cycle merge request to the analyser |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
The checker confirms on every cycle that at most one fuse enable is high and that the analyser enable and busy both track it. It also checks that the enable vector holds still during a burst, that the merge and done pulses last one cycle and fall inside or right after the burst, and that the error flag is sticky. Pulse counts per ID, the 2L+1 schedule, the exact merge position, and the repair code arriving intact in the selected fuse register depend on the length table. Only the bench's scenarios show these: its shift-register models of each fuse chain and of the analyser replay every burst. The same holds for zero-length and out-of-range IDs, and for the ignored mid-burst trigger.

// File: rtl/srfc_pkg.sv
package srfc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_UNLOAD = 3'd1,
      PH_MERGE  = 3'd2,
      PH_LOAD   = 3'd3,
      PH_DONE   = 3'd4
   } srfc_phase_e;

endpackage

// File: rtl/srfc_len_rom.sv
module srfc_len_rom #(
   parameter int unsigned N_MEM = 5,
   parameter int unsigned LEN_W = 8,
   parameter int unsigned ID_W  = 3,
   parameter logic [N_MEM*LEN_W-1:0] LEN_TABLE = '0
)(
   input  logic [ID_W-1:0]  id_i,
   output logic [LEN_W-1:0] len_o
);

   logic [LEN_W-1:0] lens [N_MEM];

   for (genvar g = 0; g < N_MEM; g++) begin : g_unpack
      assign lens[g] = LEN_TABLE[g*LEN_W +: LEN_W];
   end

   // IDs past the table read as zero length
   always_comb begin
      len_o = '0;
      for (int k = 0; k < N_MEM; k++) begin
         if (id_i == ID_W'(k)) len_o = lens[k];
      end
   end

endmodule

// File: rtl/srfc_pulse_cnt.sv
module srfc_pulse_cnt #(
   parameter int unsigned LEN_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             last_o
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load_i)              cnt_q <= load_val_i;
      else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = run_i && (cnt_q == LEN_W'(1));

endmodule

// File: rtl/srfc_en_reg.sv
module srfc_en_reg #(
   parameter int unsigned N_MEM = 5,
   parameter int unsigned ID_W  = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [ID_W-1:0]  id_i,
   output logic [N_MEM-1:0] en_o,
   output logic             ana_en_o
);

   for (genvar g = 0; g < N_MEM; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)     en_o[g] <= 1'b0;
         else if (set_i) en_o[g] <= (id_i == ID_W'(g));
         else if (clr_i) en_o[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ana_en_o <= 1'b0;
      else if (set_i) ana_en_o <= 1'b1;
      else if (clr_i) ana_en_o <= 1'b0;
   end

endmodule

// File: rtl/sr_fuse_clk_ctrl.sv
module sr_fuse_clk_ctrl
   import srfc_pkg::*;
#(
   parameter int unsigned N_MEM = 5,
   parameter int unsigned LEN_W = 8,
   parameter logic [N_MEM*LEN_W-1:0] LEN_TABLE = {8'd1, 8'd11, 8'd0, 8'd3, 8'd6},
   localparam int unsigned ID_W = (N_MEM > 1) ? $clog2(N_MEM) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             incr_i,
   input  logic [ID_W-1:0]  mem_id_i,
   output logic [N_MEM-1:0] fuse_en_o,
   output logic             ana_en_o,
   output logic             merge_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);

   if (N_MEM < 2) begin : g_bad_n
      $error("sr_fuse_clk_ctrl: N_MEM must be at least 2");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_w
      $error("sr_fuse_clk_ctrl: LEN_W must lie in 1..16");
   end

   srfc_phase_e      ph_q, ph_d;
   logic [LEN_W-1:0] sel_len, len_q, cnt_val;
   logic             idle_like, accept;
   logic             cnt_load, cnt_run, cnt_last;
   logic             en_set, en_clr;

   srfc_len_rom #(
      .N_MEM(N_MEM), .LEN_W(LEN_W), .ID_W(ID_W), .LEN_TABLE(LEN_TABLE)
   ) i_rom (
      .id_i  (mem_id_i),
      .len_o (sel_len)
   );

   assign idle_like = (ph_q == PH_IDLE) || (ph_q == PH_DONE);
   assign accept    = start_i && idle_like;
   assign cnt_run   = (ph_q == PH_UNLOAD) || (ph_q == PH_LOAD);

   always_comb begin
      ph_d     = ph_q;
      cnt_load = 1'b0;
      cnt_val  = len_q;
      en_set   = 1'b0;
      en_clr   = 1'b0;
      case (ph_q)
         PH_IDLE, PH_DONE: begin
            ph_d = PH_IDLE;
            if (accept) begin
               if (sel_len == '0) begin
                  ph_d = PH_DONE;
               end else begin
                  ph_d     = incr_i ? PH_UNLOAD : PH_LOAD;
                  cnt_load = 1'b1;
                  cnt_val  = sel_len;
                  en_set   = 1'b1;
               end
            end
         end
         PH_UNLOAD: if (cnt_last) ph_d = PH_MERGE;
         PH_MERGE: begin
            ph_d     = PH_LOAD;
            cnt_load = 1'b1;
         end
         PH_LOAD: if (cnt_last) begin
            ph_d   = PH_DONE;
            en_clr = 1'b1;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         len_q <= '0;
         err_o <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (accept) len_q <= sel_len;
         if (start_i && !idle_like) err_o <= 1'b1;
      end
   end

   srfc_pulse_cnt #(.LEN_W(LEN_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (cnt_val),
      .run_i      (cnt_run),
      .last_o     (cnt_last)
   );

   srfc_en_reg #(.N_MEM(N_MEM), .ID_W(ID_W)) i_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (en_set),
      .clr_i    (en_clr),
      .id_i     (mem_id_i),
      .en_o     (fuse_en_o),
      .ana_en_o (ana_en_o)
   );

   assign busy_o  = cnt_run || (ph_q == PH_MERGE);
   assign merge_o = (ph_q == PH_MERGE);
   assign done_o  = (ph_q == PH_DONE);

endmodule

// File: rtl/srfc_chk.sv
module srfc_chk #(
   parameter int unsigned N_MEM = 5
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [N_MEM-1:0] fuse_en_o,
   input logic             ana_en_o,
   input logic             merge_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o
);

   // R2
   one_hot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fuse_en_o));

   // R2
   busy_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == (fuse_en_o != '0));

   // R4
   ana_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ana_en_o == (fuse_en_o != '0));

   // R10
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(fuse_en_o));

   // R6
   merge_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      merge_o |-> busy_o);

   // R6
   merge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      merge_o |=> !merge_o);

   // R7
   done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> err_o);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

endmodule

bind sr_fuse_clk_ctrl srfc_chk #(.N_MEM(N_MEM)) i_srfc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .fuse_en_o (fuse_en_o),
   .ana_en_o  (ana_en_o),
   .merge_o   (merge_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/test_sr_fuse_clk_ctrl.sv
module test_sr_fuse_clk_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 5;
   localparam int IDW = 3;
   localparam int TBL [N] = '{6, 3, 0, 11, 1};

   logic           clk, rst_n, start_i, incr_i;
   logic [IDW-1:0] mem_id_i;
   logic [N-1:0]   fuse_en_o;
   logic           ana_en_o, merge_o, busy_o, done_o, err_o;

   sr_fuse_clk_ctrl i_sr_fuse_clk_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .incr_i(incr_i),
      .mem_id_i(mem_id_i), .fuse_en_o(fuse_en_o), .ana_en_o(ana_en_o),
      .merge_o(merge_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   int          n_chk = 0, n_bad = 0;
   int          pulses [N];
   int          ana_pulses, merge_cnt, merge_at, done_cnt, mismatch = 0;
   logic [63:0] ana_sr;
   logic [63:0] mem_sr [N];
   logic        prev_busy = 1'b0;
   logic [N-1:0] prev_en = '0;
   bit          err_exp = 1'b0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int tlen(input int id);
      return (id >= 0 && id < N) ? TBL[id] : 0;
   endfunction

   function automatic int exp_pulses(input int id, input bit incr);
      int l;
      l = tlen(id);
      if (l == 0) return 0;
      return incr ? 2*l + 1 : l;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // models of the analyser chain and the memory fuse chains
   always @(negedge clk) begin
      logic fdo;
      if (rst_n) begin
         fdo = 1'b0;
         if (ana_en_o) begin
            fdo = ana_sr[0];
            ana_sr = ana_sr >> 1;
            ana_pulses++;
         end
         for (int j = 0; j < N; j++) begin
            if (fuse_en_o[j]) begin
               pulses[j]++;
               if (tlen(j) > 0)
                  mem_sr[j] = (mem_sr[j] >> 1) | (64'(fdo) << (tlen(j) - 1));
            end
         end
         if (merge_o) begin
            merge_cnt++;
            merge_at = ana_pulses;
         end
         if (done_o) done_cnt++;
         if (busy_o != (fuse_en_o != '0)) mismatch++;
         if (busy_o && prev_busy && fuse_en_o != prev_en) mismatch++;
         prev_busy = busy_o;
         prev_en   = fuse_en_o;
      end
   end

   task automatic run_burst(input int id, input bit incr, input bit inject);
      int          l, exp, guard;
      logic [63:0] code, mask;
      l    = tlen(id);
      exp  = exp_pulses(id, incr);
      code = {$urandom, $urandom};
      mask = (l == 0) ? 64'd0 : ((64'd1 << l) - 64'd1);
      ana_sr = code;
      ana_pulses = 0; merge_cnt = 0; merge_at = 0; done_cnt = 0;
      for (int j = 0; j < N; j++) begin
         pulses[j] = 0;
         mem_sr[j] = '0;
      end
      start_i = 1'b1; incr_i = incr; mem_id_i = IDW'(id);
      @(negedge clk);
      start_i = 1'b0;
      if (exp == 0)
         chk(!busy_o && done_o && fuse_en_o == '0, "R8 zero-length or bad ID",
             longint'({busy_o, done_o}), 1);
      else
         chk(busy_o && fuse_en_o == N'(1 << id), "R2 one-hot enable",
             longint'(fuse_en_o), longint'(1 << id));
      if (inject) begin
         repeat (3) @(negedge clk);
         start_i = 1'b1; incr_i = 1'b0; mem_id_i = 3'd0;
         @(negedge clk);
         start_i = 1'b0;
         err_exp = 1'b1;
      end
      guard = 0;
      while (!done_o && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 100, "R7 done reached", guard, 0);
      @(negedge clk);
      if (id < N)
         chk(pulses[id] == exp, incr ? "R5 incremental pulse count" : "R3 pulse count",
             pulses[id], exp);
      for (int j = 0; j < N; j++)
         if (j != id) chk(pulses[j] == 0, "R2 unselected fuse clock idle", pulses[j], 0);
      chk(ana_pulses == exp, "R4 analyser pulses", ana_pulses, exp);
      chk(merge_cnt == ((incr && exp > 0) ? 1 : 0), "R6 merge count", merge_cnt,
          (incr && exp > 0) ? 1 : 0);
      if (incr && exp > 0)
         chk(merge_at == l + 1, "R6 merge position", merge_at, l + 1);
      chk(done_cnt == 1, "R7 single done", done_cnt, 1);
      if (!incr && exp > 0)
         chk(mem_sr[id] == (code & mask), "R3 fuse content",
             longint'(mem_sr[id]), longint'(code & mask));
      chk(err_o == err_exp, "R9 error flag", err_o, err_exp);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; start_i = 1'b0; incr_i = 1'b0; mem_id_i = '0;
      repeat (3) @(negedge clk);
      chk({fuse_en_o, ana_en_o, merge_o, busy_o, done_o, err_o} == '0, "R1 reset state",
          longint'({fuse_en_o, ana_en_o, merge_o, busy_o, done_o, err_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({fuse_en_o, ana_en_o, merge_o, busy_o, done_o, err_o} == '0, "R1 after reset",
          longint'({fuse_en_o, ana_en_o, merge_o, busy_o, done_o, err_o}), 0);

      // directed corner cases
      run_burst(0, 1'b0, 1'b0);
      run_burst(1, 1'b0, 1'b0);
      run_burst(4, 1'b0, 1'b0);
      run_burst(2, 1'b0, 1'b0);
      run_burst(6, 1'b0, 1'b0);
      run_burst(3, 1'b1, 1'b0);
      run_burst(4, 1'b1, 1'b0);
      run_burst(2, 1'b1, 1'b0);
      run_burst(7, 1'b1, 1'b0);

      // constrained random
      for (int it = 0; it < 40; it++)
         run_burst(int'($urandom % 8), bit'($urandom % 2), 1'b0);

      // trigger while busy: R9
      run_burst(3, 1'b0, 1'b1);
      run_burst(1, 1'b1, 1'b0);

      chk(mismatch == 0, "R10 enable held and tracked by busy", mismatch, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule